// File: doc/BRIEF.md
# Presettable Counter with Dual Count Enables

This block is a small synchronous binary up-counter that can be preset, cleared and chained. On each rising clock edge it clears, loads a parallel preset word, advances by one, or holds. Which of these happens is decided by a fixed priority over an active-low clear, an active-low load and two active-high count enables. Both enables must be high for the count to advance. Only the second enable, called the chain enable, also gates the terminal-count flag. That flag is high only while the count is all ones and the chain enable is high.

Wider counters are built by sharing the clock across stages and feeding each stage's terminal-count flag into the chain enable of the next, more significant stage. A parameter chooses whether the clear takes effect at once or waits for the clock edge. With the clock-edge clear, decoding one count value back into the clear input gives a glitch-free modulo-N counter. The design has no streaming data path, so all pins are plain control and status signals.

Top module: `preset_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, `count` is 0 after that edge and `tc_out` is 0. Straight after reset, `count` reads 0.
- R2: With `RESET_SYNC` = 0, `count` goes to 0 as soon as `rst_n` goes low, without waiting for a clock edge.
- R3: With `RESET_SYNC` = 1, a low `rst_n` leaves `count` unchanged until the next rising edge, and `count` is 0 after that edge.
- R4: If `rst_n` is high and `load_n` is low at a rising edge, `count` takes `preset` after that edge. Bit 0 is the least significant bit. The enables have no effect on that edge.
- R5: The clear wins over the load: with both `rst_n` and `load_n` low at an edge, `count` becomes 0.
- R6: If `rst_n` and `load_n` are both high, `count` advances by one only when `en_cnt` and `en_chain` are both high. Otherwise it keeps its value.
- R7: Advancing from the all-ones value (15 for 4 bits) gives 0.
- R8: `tc_out` is high exactly when `en_chain` is high and `count` is all ones. `en_cnt` has no effect on `tc_out`.
- R9: Two stages that share the clock, with the low stage's `tc_out` driving the high stage's `en_chain`, count together as one binary counter of twice the width.
- R10: With `RESET_SYNC` = 1 and `rst_n` driven low when `count` equals N-1, the counter runs through 0 to N-1 and repeats (modulo N).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear; immediate or edge-timed depending on RESET_SYNC |
| load_n | input | 1 | Active-low parallel load of `preset` |
| preset | input | WIDTH | Preset word, bit 0 least significant |
| en_cnt | input | 1 | Count enable that does not affect `tc_out` |
| en_chain | input | 1 | Count enable that also gates `tc_out` |
| count | output | WIDTH | Current count value |
| tc_out | output | 1 | Terminal-count flag for chaining stages |

## Verification
A clear, load or count step shows on `count` one rising edge after the controls are set up. The exception is the immediate clear, which shows before the next edge. `tc_out` follows `en_chain` and `count` in the same cycle, with no register in between. The bench changes every input just after a falling edge and reads the outputs just before the next falling edge, so each sample comes exactly one rising edge after the stimulus it checks. To check the immediate clear, the bench drops `rst_n` partway through the low phase and reads `count` before the next rising edge. It reads at that same point to confirm that the edge-timed variant has not yet moved.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  // Operation chosen for the next rising edge (clear is handled by the register)
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_PLOAD = 2'd2
  } pcnt_op_e;
endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
  import pcnt_pkg::*;
(
  input  logic     load_n,
  input  logic     en_cnt,
  input  logic     en_chain,
  output pcnt_op_e op
);
  // Load outranks counting; counting needs both enables
  always_comb begin
    if (!load_n)                 op = OP_PLOAD;
    else if (en_cnt && en_chain) op = OP_STEP;
    else                         op = OP_HOLD;
  end
endmodule

// File: rtl/pcnt_reg.sv
module pcnt_reg
  import pcnt_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter bit RESET_SYNC = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pcnt_op_e         op,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] nxt;

  always_comb begin
    case (op)
      OP_PLOAD: nxt = preset;
      OP_STEP:  nxt = q + ONE;
      default:  nxt = q;
    endcase
  end

  generate
    if (RESET_SYNC) begin : g_sync_clear
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_async_clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/pcnt_tc.sv
module pcnt_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_chain,
  output logic             tc
);
  // AND chain across the bits, then gated by the chain enable
  logic [WIDTH:0] chain;
  assign chain[0] = en_chain;
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_and
      assign chain[b+1] = chain[b] & q[b];
    end
  endgenerate
  assign tc = chain[WIDTH];
endmodule

// File: rtl/preset_counter.sv
module preset_counter
  import pcnt_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter bit RESET_SYNC = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             en_cnt,
  input  logic             en_chain,
  output logic [WIDTH-1:0] count,
  output logic             tc_out
);
  pcnt_op_e op;

  pcnt_ctrl u_ctrl (
    .load_n   (load_n),
    .en_cnt   (en_cnt),
    .en_chain (en_chain),
    .op       (op)
  );

  pcnt_reg #(.WIDTH(WIDTH), .RESET_SYNC(RESET_SYNC)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .preset (preset),
    .q      (count)
  );

  pcnt_tc #(.WIDTH(WIDTH)) u_tc (
    .q        (count),
    .en_chain (en_chain),
    .tc       (tc_out)
  );
endmodule

// File: rtl/preset_counter_chk.sv
module preset_counter_chk #(
  parameter int WIDTH      = 4,
  parameter bit RESET_SYNC = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic [WIDTH-1:0] preset,
  input logic             en_cnt,
  input logic             en_chain,
  input logic [WIDTH-1:0] count,
  input logic             tc_out
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  // R1: the first edge after a clear sees a zero count
  p_clear_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> count == '0);

  // R4: a load copies the preset word
  p_load_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> count == $past(preset));

  // R6, R7: both enables advance by one, with wrap
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_cnt && en_chain) |=> count == $past(count) + ONE);

  // R6: otherwise the count holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_cnt && en_chain)) |=> $stable(count));

  // R8: a low chain enable kills the flag
  p_tc_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_chain |-> !tc_out);

  // R8: the flag is only raised at all ones
  p_tc_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |-> count == '1);

  generate
    if (!RESET_SYNC) begin : g_async_chk
      // R2: an immediate clear keeps the count at zero while held
      p_async_clear_r2: assert property (@(posedge clk)
        ($past(!rst_n) && !rst_n) |-> count == '0);
    end
  endgenerate
endmodule

bind preset_counter preset_counter_chk #(.WIDTH(WIDTH), .RESET_SYNC(RESET_SYNC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_n   (load_n),
  .preset   (preset),
  .en_cnt   (en_cnt),
  .en_chain (en_chain),
  .count    (count),
  .tc_out   (tc_out)
);

// File: tb/preset_counter_test.sv
module preset_counter_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Shared 4-bit stimulus for the asynchronous (uut) and synchronous variants
  logic       rst_n, load_n, en_cnt, en_chain;
  logic [3:0] preset;
  logic [3:0] a_cnt, s_cnt;
  logic       a_tc, s_tc;

  preset_counter #(.WIDTH(4), .RESET_SYNC(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .preset(preset),
    .en_cnt(en_cnt), .en_chain(en_chain), .count(a_cnt), .tc_out(a_tc));

  logic s_rst_n;
  preset_counter #(.WIDTH(4), .RESET_SYNC(1'b1)) u_sync (
    .clk(clk), .rst_n(s_rst_n), .load_n(load_n), .preset(preset),
    .en_cnt(en_cnt), .en_chain(en_chain), .count(s_cnt), .tc_out(s_tc));

  // Two-stage cascade
  logic       c_rst_n, c_load_n, c_en;
  logic [7:0] c_pre;
  logic [3:0] c_lo, c_hi;
  logic       c_lo_tc, c_hi_tc;

  preset_counter #(.WIDTH(4)) u_lo (
    .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .preset(c_pre[3:0]),
    .en_cnt(1'b1), .en_chain(c_en), .count(c_lo), .tc_out(c_lo_tc));
  preset_counter #(.WIDTH(4)) u_hi (
    .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .preset(c_pre[7:4]),
    .en_cnt(1'b1), .en_chain(c_lo_tc), .count(c_hi), .tc_out(c_hi_tc));

  // Modulo-11 from decoded synchronous clear
  logic       m_go_n;
  logic [3:0] m_cnt;
  logic       m_tc;
  logic       m_rst_n;
  assign m_rst_n = m_go_n && (m_cnt != 4'd10);
  preset_counter #(.WIDTH(4), .RESET_SYNC(1'b1)) u_mod (
    .clk(clk), .rst_n(m_rst_n), .load_n(1'b1), .preset(4'd0),
    .en_cnt(1'b1), .en_chain(1'b1), .count(m_cnt), .tc_out(m_tc));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #3000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  logic [3:0] exp_q;
  logic [7:0] exp_c;
  string      tag;

  initial begin
    rst_n = 0; s_rst_n = 0; load_n = 1; en_cnt = 0; en_chain = 0; preset = 0;
    c_rst_n = 0; c_load_n = 1; c_en = 0; c_pre = 0; m_go_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 async reset count", a_cnt, 0);
    check("R1 sync reset count", s_cnt, 0);
    check("R1 reset carry", a_tc, 0);
    rst_n = 1; s_rst_n = 1;

    // R2: immediate clear, observed before the next rising edge
    load_n = 0; preset = 4'd9;
    @(posedge clk); @(negedge clk);
    load_n = 1;
    check("R4 load 9 async", a_cnt, 9);
    check("R4 load 9 sync", s_cnt, 9);
    #3 rst_n = 0; s_rst_n = 0;
    #2;
    check("R2 immediate clear", a_cnt, 0);
    check("R3 no clear before edge", s_cnt, 9);
    @(posedge clk); @(negedge clk);
    check("R3 clear at edge", s_cnt, 0);
    check("R2 held clear", a_cnt, 0);

    // Directed wrap run: 12,13,14,15,0,1,2 then hold
    rst_n = 1; s_rst_n = 1; load_n = 0; preset = 4'd12;
    @(posedge clk); @(negedge clk);
    load_n = 1; en_cnt = 1; en_chain = 1;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk); @(negedge clk);
      check("R7 wrap sequence", a_cnt, (12 + k) % 16);
    end
    en_cnt = 0;
    @(posedge clk); @(negedge clk);
    check("R6 hold after drop", a_cnt, 2);

    // Sweep of control combinations
    exp_q = 4'd2;
    for (int i = 0; i < 1024; i++) begin
      rst_n    = (i % 37) != 3;
      s_rst_n  = rst_n;
      load_n   = (i % 5) != 2 || (i % 35) == 17;
      en_cnt   = (i % 3) != 0;
      en_chain = ((i / 2) % 4) != 1;
      preset   = 4'(i * 7 + i / 16);
      if (!rst_n) begin
        tag = load_n ? "R1" : "R5";
        exp_q = 4'd0;
      end else if (!load_n) begin
        tag = "R4";
        exp_q = preset;
      end else if (en_cnt && en_chain) begin
        tag = (exp_q == 4'd15) ? "R7" : "R6";
        exp_q = exp_q + 4'd1;
      end else begin
        tag = "R6";
      end
      @(posedge clk); @(negedge clk);
      check({tag, " async count"}, a_cnt, exp_q);
      check({tag, " sync count"}, s_cnt, exp_q);
      check("R8 carry", a_tc, int'(en_chain && exp_q == 4'd15));
      check("R8 carry sync", s_tc, int'(en_chain && exp_q == 4'd15));
    end
    rst_n = 1; s_rst_n = 1;

    // R9: cascade
    c_rst_n = 1; c_load_n = 0; c_pre = 8'hE9;
    @(posedge clk); @(negedge clk);
    c_load_n = 0;
    exp_c = 8'hE9;
    check("R9 cascade load", {c_hi, c_lo}, exp_c);
    c_load_n = 1;
    for (int k = 0; k < 600; k++) begin
      c_en = (k % 13) != 5;
      if (c_en) exp_c = exp_c + 8'd1;
      @(posedge clk); @(negedge clk);
      check("R9 cascade count", {c_hi, c_lo}, exp_c);
    end

    // R10: modulo 11
    m_go_n = 1;
    for (int k = 1; k <= 50; k++) begin
      @(posedge clk); @(negedge clk);
      check("R10 modulo 11", m_cnt, k % 11);
    end

    finish_run();
  end
endmodule